// File: doc/BRIEF.md
# BCD Time Alarm Comparator

This block holds an alarm time as four packed-BCD fields: seconds, minutes, hour and day of month. The timekeeping core supplies the current time on parallel BCD inputs and pulses a one-cycle strobe once per second. On each strobe the block compares the current time with the stored alarm. If all four fields are equal, it sets a sticky alarm flag.

The flag is reported in a shared status byte, next to a watchdog flag and a battery-low indication that arrive from elsewhere. Reading that status byte clears the alarm flag.

An interrupt output follows the flag under two enables:
- one for normal operation;
- one that also allows the interrupt while the system runs from its backup supply.

Software reaches the alarm fields, the enables and the status byte through a small synchronous register port with registered read data.

Top module: `alarm_cmp`

## Requirements
- R1: After reset the alarm flag, both interrupt enables, all four alarm fields and the read data are zero, and `alarm_irq` is low.
- R2: The alarm fields sit at offsets 2 (seconds), 3 (minutes), 4 (hour) and 5 (day of month). A write stores all 8 bits as given, and a read returns them unchanged, including non-BCD values.
- R3: When `sec_tick` is high and all four alarm fields equal the current time inputs, the alarm flag is set at that clock edge.
- R4: The flag does not set when any one field differs, or when the time matches but `sec_tick` is low.
- R5: The status byte at offset 0 returns `wdog_flag_in` at bit 7, the alarm flag at bit 6 and `batt_low_in` at bit 4, with all other bits zero. The returned value is the one from before any clear caused by that same read.
- R6: A read of offset 0 clears the alarm flag at that edge, and `alarm_irq` falls together with it. If a match strobe lands on the same edge as the read, the flag stays set.
- R7: `alarm_irq` is high only while the alarm flag is set and the enable at bit 7 of offset 6 is 1.
- R8: While `backup_mode` is high, `alarm_irq` also requires bit 5 of offset 6 to be 1. While `backup_mode` is low, that bit has no effect.
- R9: Offset 6 reads back bits 7 and 5 as written and zero elsewhere. Offsets 1 and 7 read zero, and writes to them change nothing.
- R10: Writes to offset 0 do not change the alarm flag.
- R11: An alarm field holding a non-BCD nibble never matches a valid BCD time, so no strobe sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| backup_mode | input | 1 | High while running from backup supply |
| wdog_flag_in | input | 1 | Watchdog flag, shown in status byte |
| batt_low_in | input | 1 | Battery-low indication, shown in status byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered one cycle after `reg_rd` |
| alarm_irq | output | 1 | Gated alarm interrupt |

## Verification
The hardest case to reach from the ports is a match strobe arriving on the very edge that reads and clears the status byte. In a normal run the two are seconds apart, and losing the alarm there would be silent. The bench drives the strobe and the read in the same cycle on purpose. It then expects that read to return the old status byte (flag clear) and the next read to show the flag. The other vectors change one field at a time away from a full match, including the field limits and a non-BCD seconds value.

// File: rtl/alarm_cmp_pkg.sv
// Shared constants for the alarm comparator: register offsets and bit
// positions. Assumes an 8-bit data path and a 3-bit offset space.
package alarm_cmp_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int NUM_FIELDS = 4;

    localparam int OFS_STATUS = 0;
    localparam int OFS_FIELD0 = 2;   // seconds; fields follow consecutively
    localparam int OFS_INTCTL = 6;

    localparam int ST_WDOG  = 7;
    localparam int ST_ALARM = 6;
    localparam int ST_BATT  = 4;
    localparam int CTL_EN   = 7;
    localparam int CTL_BKEN = 5;

    typedef enum logic [1:0] {FLD_SEC, FLD_MIN, FLD_HOUR, FLD_DAY} field_e;
endpackage

// File: rtl/alarm_regfile.sv
// Storage for the alarm fields and the two interrupt enables.
// Assumes single-cycle write strobes; fields keep all bits as written.
module alarm_regfile
    import alarm_cmp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NF = NUM_FIELDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [NF-1:0][DW-1:0] fields,
    output logic                 en_norm,
    output logic                 en_bkup
);
    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_fld
            localparam logic [AW-1:0] MY_OFS = AW'(OFS_FIELD0 + g);
            // Capture a write aimed at this field's offset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fields[g] <= '0;
                else if (wr && addr == MY_OFS)
                    fields[g] <= wdata;
            end
        end
    endgenerate

    // Capture the two enable bits of the interrupt-control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_norm <= 1'b0;
            en_bkup <= 1'b0;
        end else if (wr && addr == AW'(OFS_INTCTL)) begin
            en_norm <= wdata[CTL_EN];
            en_bkup <= wdata[CTL_BKEN];
        end
    end
endmodule

// File: rtl/alarm_match.sv
// Per-field equality of the alarm against the current time.
// Assumes the time inputs are valid BCD, so non-BCD alarm fields never match.
module alarm_match
    import alarm_cmp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NF = NUM_FIELDS
) (
    input  logic [NF-1:0][DW-1:0] alarm,
    input  logic [NF-1:0][DW-1:0] now,
    output logic                  all_eq
);
    logic [NF-1:0] eq;
    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_cmp
            assign eq[g] = (alarm[g] == now[g]);
        end
    endgenerate

    // Every field has to agree for a match.
    assign all_eq = &eq;
endmodule

// File: rtl/alarm_flag.sv
// Sticky alarm flag and gated interrupt. A set takes priority over a
// clear-on-read landing on the same edge.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic clr,
    input  logic en_norm,
    input  logic en_bkup,
    input  logic backup,
    output logic flag,
    output logic irq
);
    // Set on a strobed match, otherwise clear on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (tick && hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // Interrupt follows the flag under the enables for the present supply mode.
    assign irq = flag & en_norm & (~backup | en_bkup);
endmodule

// File: rtl/alarm_cmp.sv
// Top of the alarm comparator: register port, comparison, flag and readback.
// Read data is registered; a status read clears the alarm flag on the same edge.
module alarm_cmp
    import alarm_cmp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NF = NUM_FIELDS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_day,
    input  logic          backup_mode,
    input  logic          wdog_flag_in,
    input  logic          batt_low_in,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          alarm_irq
);
    logic [NF-1:0][DW-1:0] fields;
    logic [NF-1:0][DW-1:0] now;
    logic                  en_norm, en_bkup;
    logic                  all_match;
    logic                  alarm_flag_q;
    logic                  status_rd;
    logic [DW-1:0]         rd_val;

    assign now[FLD_SEC]  = cur_sec;
    assign now[FLD_MIN]  = cur_min;
    assign now[FLD_HOUR] = cur_hour;
    assign now[FLD_DAY]  = cur_day;
    assign status_rd     = reg_rd && reg_addr == AW'(OFS_STATUS);

    alarm_regfile #(.DW(DW), .AW(AW), .NF(NF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .fields(fields), .en_norm(en_norm), .en_bkup(en_bkup)
    );

    alarm_match #(.DW(DW), .NF(NF)) u_match (
        .alarm(fields), .now(now), .all_eq(all_match)
    );

    alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .hit(all_match),
        .clr(status_rd), .en_norm(en_norm), .en_bkup(en_bkup),
        .backup(backup_mode), .flag(alarm_flag_q), .irq(alarm_irq)
    );

    // Select the register value addressed by the read port.
    always_comb begin
        rd_val = '0;
        if (reg_addr == AW'(OFS_STATUS)) begin
            rd_val[ST_WDOG]  = wdog_flag_in;
            rd_val[ST_ALARM] = alarm_flag_q;
            rd_val[ST_BATT]  = batt_low_in;
        end else if (reg_addr == AW'(OFS_INTCTL)) begin
            rd_val[CTL_EN]   = en_norm;
            rd_val[CTL_BKEN] = en_bkup;
        end
        for (int i = 0; i < NF; i++)
            if (reg_addr == AW'(OFS_FIELD0 + i))
                rd_val = fields[i];
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_val;
    end
endmodule

// File: rtl/alarm_cmp_chk.sv
// Assertion checker for alarm_cmp, attached by bind.
module alarm_cmp_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_tick,
    input logic          all_match,
    input logic          flag,
    input logic          en_norm,
    input logic          en_bkup,
    input logic          backup_mode,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic          alarm_irq
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !alarm_irq); // R1
    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && all_match) |=> flag); // R3
    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !sec_tick) |=> !flag); // R4
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == '0 && !(sec_tick && all_match)) |=> (!flag && !alarm_irq)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_rd && reg_addr == '0)) |=> flag); // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (flag && en_norm)); // R7
    AST_IRQ_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && backup_mode) |-> en_bkup); // R8
endmodule

bind alarm_cmp alarm_cmp_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .all_match(all_match),
    .flag(alarm_flag_q), .en_norm(en_norm), .en_bkup(en_bkup),
    .backup_mode(backup_mode), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .alarm_irq(alarm_irq)
);

// File: tb/tb_alarm_cmp.sv
module tb_alarm_cmp;
    logic       clk = 0, rst_n = 0, sec_tick = 0, backup_mode = 0;
    logic       wdog_flag_in = 0, batt_low_in = 0, reg_wr = 0, reg_rd = 0;
    logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_day = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata, rv;
    logic       alarm_irq;
    int         total = 0, bad = 0;

    alarm_cmp dut (.*);

    always #5 clk = ~clk;

    // {alarm sec,min,hour,day, time sec,min,hour,day, expect}
    localparam logic [64:0] VEC [0:7] = '{
        {32'h30151205, 32'h30151205, 1'b1},
        {32'h30151205, 32'h31151205, 1'b0},
        {32'h30151205, 32'h30161205, 1'b0},
        {32'h30151205, 32'h30151305, 1'b0},
        {32'h30151205, 32'h30151206, 1'b0},
        {32'h59592331, 32'h59592331, 1'b1},
        {32'h00000001, 32'h00000001, 1'b1},
        {32'h5A000001, 32'h50000001, 1'b0}   // R11 non-BCD seconds
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic set_time(logic [31:0] t);
        {cur_sec, cur_min, cur_hour, cur_day} = t;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
    endtask

    task automatic set_alarm(logic [31:0] a);
        wr(3'd2, a[31:24]); wr(3'd3, a[23:16]); wr(3'd4, a[15:8]); wr(3'd5, a[7:0]);
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 irq", {7'b0, alarm_irq}, 8'h00);
        check("R1 rdata", reg_rdata, 8'h00);
        rd(3'd0, rv); check("R1 status", rv, 8'h00);
        for (int i = 2; i <= 6; i++) begin
            rd(3'(i), rv); check("R1 reg", rv, 8'h00);
        end

        // Vector table: R3 R4 R11
        for (int i = 0; i < 8; i++) begin
            set_alarm(VEC[i][64:33]);
            set_time(VEC[i][32:1]);
            tick();
            rd(3'd0, rv);
            check("R3/R4/R11 vector", {7'b0, rv[6]}, {7'b0, VEC[i][0]});
        end

        // R2 readback, including non-BCD
        wr(3'd2, 8'h7F); wr(3'd5, 8'hFF);
        rd(3'd2, rv); check("R2 sec", rv, 8'h7F);
        rd(3'd5, rv); check("R2 day", rv, 8'hFF);

        // R4 match without strobe
        set_alarm(32'h10203004); set_time(32'h10203004);
        repeat (4) @(negedge clk);
        rd(3'd0, rv); check("R4 no tick", rv, 8'h00);

        // R3 timing / R7: enable off keeps irq low
        tick();
        check("R7 irq no en", {7'b0, alarm_irq}, 8'h00);
        wr(3'd6, 8'h80);
        check("R7 irq en", {7'b0, alarm_irq}, 8'h01);

        // R10 write to status ignored; R5 layout
        wr(3'd0, 8'h00);
        wdog_flag_in = 1; batt_low_in = 1;
        rd(3'd0, rv); check("R5 status", rv, 8'hD0);
        check("R6 irq after read", {7'b0, alarm_irq}, 8'h00);
        rd(3'd0, rv); check("R6 cleared", rv, 8'h90);
        wdog_flag_in = 0; batt_low_in = 0;

        // R3 immediate set after strobe edge
        tick();
        check("R3 irq next cycle", {7'b0, alarm_irq}, 8'h01);

        // R10 explicit
        wr(3'd0, 8'hFF);
        rd(3'd0, rv); check("R10 status write ignored", rv, 8'h40);

        // R8 backup gating
        tick();
        backup_mode = 1; #1;
        check("R8 backup no en", {7'b0, alarm_irq}, 8'h00);
        wr(3'd6, 8'hA0);
        check("R8 backup en", {7'b0, alarm_irq}, 8'h01);
        wr(3'd6, 8'h80); backup_mode = 0; #1;
        check("R8 normal ignores bk bit", {7'b0, alarm_irq}, 8'h01);

        // R9 register readback and unused offsets
        wr(3'd6, 8'hFF);
        rd(3'd6, rv); check("R9 intctl", rv, 8'hA0);
        wr(3'd1, 8'hFF); rd(3'd1, rv); check("R9 ofs1", rv, 8'h00);
        wr(3'd7, 8'hFF); rd(3'd7, rv); check("R9 ofs7", rv, 8'h00);
        rd(3'd4, rv); check("R9 no alias", rv, 8'h30);

        // R6 coincident strobe and status read: set wins
        rd(3'd0, rv);
        @(negedge clk); sec_tick = 1; reg_rd = 1; reg_addr = 3'd0;
        @(negedge clk); sec_tick = 0; reg_rd = 0;
        check("R6 coincident rdata", reg_rdata, 8'h00);
        rd(3'd0, rv); check("R6 coincident kept", rv, 8'h40);

        // R1 reset clears everything again
        tick();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        check("R1 irq after reset", {7'b0, alarm_irq}, 8'h00);
        rd(3'd6, rv); check("R1 enables", rv, 8'h00);
        rd(3'd0, rv); check("R1 flag", rv, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule